// File: doc/BRIEF.md
# Data Breakpoint Match Unit

This block compares each data memory access with a bank of programmable watch pairs. Every pair has two 64-bit words. The even word holds a watch address. The odd word holds a read enable, a write enable, a four-bit privilege mask and a 56-bit address mask. An access carries its address, its direction, the current privilege level (0 to 3), a qualifying predicate and a speculative-load flag. The unit reports one of two things: a breakpoint fault, or a deferred hit when deferral applies to a speculative load. Alongside it gives a status vector showing which of the four lowest pairs matched.

A global debug enable gates all matching. A one-shot skip flag silences the unit for the access in progress. The skip flag is armed by a pulse and disarmed by an access-done pulse. The watch words are loaded through a word index, a data word and a write strobe. Results are registered and appear one cycle after the access is presented.

Top module: `dbg_data_watch`

## Requirements
- R1: Synchronous active-high reset clears all watch words and the skip flag. With `bp_fault`, `bp_defer` and `bp_status` at 0 after reset, no access can hit until a pair is programmed.
- R2: When `cfg_we` is 1, word `cfg_idx` is loaded with `cfg_wdata`. Pair p uses word 2p as its address and word 2p+1 as its control. The new value is used from the next cycle, so an access presented in the same cycle as the write is judged against the old contents.
- R3: In a control word, bits 55:0 are an address mask. Access address bits 55:0 are compared with the watch address only where the mask bit is 1. Address bits 63:56 must always be equal.
- R4: A read (`acc_write`=0) can hit a pair only if bit 63 of the control word is 1. A write (`acc_write`=1) can hit only if bit 62 is 1. Bits 61:60 have no effect.
- R5: An access at privilege level L (0 to 3) can hit a pair only if bit 56+L of the control word is 1.
- R6: While `dbg_enable` is 0, no access produces a fault, a deferral or a status bit.
- R7: An access whose `acc_qp` is 0 produces no fault, deferral or status bit.
- R8: A `skip_arm` pulse arms the skip flag. `acc_done` disarms it. If both are 1 in the same cycle, the flag stays armed. Any access presented while the flag is armed reports nothing.
- R9: `bp_status` bit k (k = 0 to 3) is 1 when pair k matched the reported access. Several bits may be 1 together. Pairs 4 and above can raise a fault or deferral but never set a status bit.
- R10: When `defer_spec` is 1 and the access is a speculative read (`acc_spec`=1, `acc_write`=0), a match raises `bp_defer` instead of `bp_fault`. Otherwise a match raises `bp_fault`. The two outputs are never 1 together.
- R11: Outputs are registered. They reflect the access presented in the previous cycle and are all 0 after a cycle with `acc_valid` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Watch word write strobe |
| cfg_idx | input | $clog2(2*NUM_PAIRS) | Watch word index |
| cfg_wdata | input | 64 | Watch word data |
| acc_valid | input | 1 | Access present this cycle |
| acc_addr | input | 64 | Access address |
| acc_write | input | 1 | 1 for write, 0 for read |
| acc_pl | input | 2 | Current privilege level |
| acc_qp | input | 1 | Qualifying predicate of the access |
| acc_spec | input | 1 | Access is a speculative load |
| dbg_enable | input | 1 | Global data-watch enable |
| defer_spec | input | 1 | Defer hits on speculative loads |
| skip_arm | input | 1 | Arm the one-shot skip flag |
| acc_done | input | 1 | Access completed; disarms skip flag |
| bp_fault | output | 1 | Registered breakpoint fault |
| bp_defer | output | 1 | Registered deferred hit |
| bp_status | output | 4 | Registered match status of pairs 0 to 3 |

## Verification
A watch word write and an access can fall in the same cycle. The access must then be judged against the contents from before the write. The bench drives both in one cycle, once by a directed step that disables a pair while reading its address and then many times under random stimulus. A reference model that applies writes only after the edge predicts the result. Arming and disarming the skip flag can also coincide; the bench pulses both together and expects the following access to stay silent.

// File: rtl/dwatch_pkg.sv
package dwatch_pkg;

    localparam int WORD_W  = 64;
    localparam int AMASK_W = 56;
    localparam int PLM_W   = 4;
    localparam int PL_W    = 2;
    localparam int RPT_W   = 4;
    localparam int HIGH_W  = WORD_W - AMASK_W;

    // Control word of a watch pair, most significant field first.
    typedef struct packed {
        logic               rd_en;
        logic               wr_en;
        logic [1:0]         rsvd;
        logic [PLM_W-1:0]   plm;
        logic [AMASK_W-1:0] amask;
    } bp_ctl_t;

    typedef struct packed {
        logic [WORD_W-1:0] base;
        bp_ctl_t           ctl;
    } bp_pair_t;

    // Low bits compared under mask, high bits always compared.
    function automatic logic addr_hit(input logic [WORD_W-1:0]  base,
                                      input logic [WORD_W-1:0]  addr,
                                      input logic [AMASK_W-1:0] amask);
        logic [WORD_W-1:0] diff;
        diff = base ^ addr;
        return ((diff[AMASK_W-1:0] & amask) == '0) &&
               (diff[WORD_W-1:AMASK_W] == '0);
    endfunction

    function automatic logic kind_ok(input logic rd_en, input logic wr_en,
                                     input logic is_write);
        return is_write ? wr_en : rd_en;
    endfunction

    function automatic logic plm_ok(input logic [PLM_W-1:0] plm,
                                    input logic [PL_W-1:0]  pl);
        return plm[pl];
    endfunction

endpackage

// File: rtl/dwatch_regfile.sv
module dwatch_regfile import dwatch_pkg::*; #(
    parameter int NUM_PAIRS = 6,
    localparam int NUM_WORDS = 2 * NUM_PAIRS,
    localparam int IDX_W     = $clog2(NUM_WORDS)
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           we_i,
    input  logic [IDX_W-1:0]               idx_i,
    input  logic [WORD_W-1:0]              wdata_i,
    output bp_pair_t [NUM_PAIRS-1:0]       pairs_o
);

    localparam logic [IDX_W:0] WORD_LIM = (IDX_W+1)'(NUM_WORDS);

    logic [WORD_W-1:0] word_q [NUM_WORDS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < NUM_WORDS; k++) begin
                word_q[k] <= '0;
            end
        end else if (we_i && ({1'b0, idx_i} < WORD_LIM)) begin
            word_q[idx_i] <= wdata_i;
        end
    end

    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
        assign pairs_o[p].base = word_q[2*p];
        assign pairs_o[p].ctl  = bp_ctl_t'(word_q[2*p+1]);
    end

endmodule

// File: rtl/dwatch_pair_cmp.sv
module dwatch_pair_cmp import dwatch_pkg::*; (
    input  bp_pair_t          pair_i,
    input  logic [WORD_W-1:0] addr_i,
    input  logic              write_i,
    input  logic [PL_W-1:0]   pl_i,
    output logic              hit_o
);

    logic [1:0] unused_rsvd;
    assign unused_rsvd = pair_i.ctl.rsvd;

    always_comb begin
        hit_o = addr_hit(pair_i.base, addr_i, pair_i.ctl.amask) &&
                kind_ok(pair_i.ctl.rd_en, pair_i.ctl.wr_en, write_i) &&
                plm_ok(pair_i.ctl.plm, pl_i);
    end

endmodule

// File: rtl/dwatch_oneshot.sv
module dwatch_oneshot (
    input  logic clk,
    input  logic rst,
    input  logic arm_i,
    input  logic done_i,
    output logic armed_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_o <= 1'b0;
        end else if (arm_i) begin
            armed_o <= 1'b1;
        end else if (done_i) begin
            armed_o <= 1'b0;
        end
    end

endmodule

// File: rtl/dbg_data_watch.sv
module dbg_data_watch import dwatch_pkg::*; #(
    parameter int NUM_PAIRS = 6,
    localparam int IDX_W = $clog2(2 * NUM_PAIRS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [WORD_W-1:0] cfg_wdata,
    input  logic              acc_valid,
    input  logic [WORD_W-1:0] acc_addr,
    input  logic              acc_write,
    input  logic [PL_W-1:0]   acc_pl,
    input  logic              acc_qp,
    input  logic              acc_spec,
    input  logic              dbg_enable,
    input  logic              defer_spec,
    input  logic              skip_arm,
    input  logic              acc_done,
    output logic              bp_fault,
    output logic              bp_defer,
    output logic [RPT_W-1:0]  bp_status
);

    bp_pair_t [NUM_PAIRS-1:0] pairs;
    logic [NUM_PAIRS-1:0]     raw_hit;
    logic [NUM_PAIRS-1:0]     matched;
    logic                     skip_armed;
    logic                     qualify;
    logic                     any_hit;
    logic                     take_defer;

    dwatch_regfile #(.NUM_PAIRS(NUM_PAIRS)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .we_i    (cfg_we),
        .idx_i   (cfg_idx),
        .wdata_i (cfg_wdata),
        .pairs_o (pairs)
    );

    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_cmp
        dwatch_pair_cmp u_cmp (
            .pair_i  (pairs[p]),
            .addr_i  (acc_addr),
            .write_i (acc_write),
            .pl_i    (acc_pl),
            .hit_o   (raw_hit[p])
        );
    end

    dwatch_oneshot u_skip (
        .clk     (clk),
        .rst     (rst),
        .arm_i   (skip_arm),
        .done_i  (acc_done),
        .armed_o (skip_armed)
    );

    always_comb begin
        qualify    = acc_valid && dbg_enable && acc_qp && !skip_armed;
        matched    = raw_hit & {NUM_PAIRS{qualify}};
        any_hit    = |matched;
        take_defer = defer_spec && acc_spec && !acc_write;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bp_fault  <= 1'b0;
            bp_defer  <= 1'b0;
            bp_status <= '0;
        end else begin
            bp_fault  <= any_hit && !take_defer;
            bp_defer  <= any_hit && take_defer;
            bp_status <= matched[RPT_W-1:0];
        end
    end

endmodule

// File: rtl/dwatch_chk.sv
module dwatch_chk import dwatch_pkg::*; (
    input logic             clk,
    input logic             rst,
    input logic             acc_valid,
    input logic             acc_write,
    input logic             acc_qp,
    input logic             acc_spec,
    input logic             dbg_enable,
    input logic             defer_spec,
    input logic             skip_armed,
    input logic             bp_fault,
    input logic             bp_defer,
    input logic [RPT_W-1:0] bp_status
);

    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!bp_fault && !bp_defer && bp_status == '0));

    assert_disabled_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        !dbg_enable |=> (!bp_fault && !bp_defer && bp_status == '0));

    assert_pred_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        !acc_qp |=> (!bp_fault && !bp_defer && bp_status == '0));

    assert_skip_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        (skip_armed && acc_valid) |=> (!bp_fault && !bp_defer && bp_status == '0));

    assert_status_reported_R9: assert property (@(posedge clk) disable iff (rst)
        (bp_status != '0) |-> (bp_fault || bp_defer));

    assert_fault_defer_excl_R10: assert property (@(posedge clk) disable iff (rst)
        !(bp_fault && bp_defer));

    assert_defer_spec_only_R10: assert property (@(posedge clk) disable iff (rst)
        bp_defer |-> $past(defer_spec && acc_spec && !acc_write));

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        !acc_valid |=> (!bp_fault && !bp_defer && bp_status == '0));

endmodule

bind dbg_data_watch dwatch_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .acc_valid  (acc_valid),
    .acc_write  (acc_write),
    .acc_qp     (acc_qp),
    .acc_spec   (acc_spec),
    .dbg_enable (dbg_enable),
    .defer_spec (defer_spec),
    .skip_armed (skip_armed),
    .bp_fault   (bp_fault),
    .bp_defer   (bp_defer),
    .bp_status  (bp_status)
);

// File: tb/test_dbg_data_watch.sv
`timescale 1ns/1ps
module test_dbg_data_watch;

    localparam int NP = 6;
    localparam int NW = 2 * NP;
    localparam int IW = $clog2(NW);

    logic          clk = 1'b0;
    logic          rst;
    logic          cfg_we;
    logic [IW-1:0] cfg_idx;
    logic [63:0]   cfg_wdata;
    logic          acc_valid, acc_write, acc_qp, acc_spec;
    logic [63:0]   acc_addr;
    logic [1:0]    acc_pl;
    logic          dbg_enable, defer_spec, skip_arm, acc_done;
    logic          bp_fault, bp_defer;
    logic [3:0]    bp_status;

    int checks = 0;
    int errors = 0;

    logic [63:0] m_word [NW];
    logic        m_skip;

    always #2 clk = ~clk;

    dbg_data_watch #(.NUM_PAIRS(NP)) i_dbg_data_watch (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
        .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_write(acc_write), .acc_pl(acc_pl),
        .acc_qp(acc_qp), .acc_spec(acc_spec), .dbg_enable(dbg_enable), .defer_spec(defer_spec),
        .skip_arm(skip_arm), .acc_done(acc_done),
        .bp_fault(bp_fault), .bp_defer(bp_defer), .bp_status(bp_status)
    );

    function automatic logic [63:0] mk_ctl(input logic rd, input logic wr,
                                           input logic [3:0] plm, input logic [55:0] mask);
        return {rd, wr, 2'b00, plm, mask};
    endfunction

    // Expected {fault, defer, status} from the requirements and the model state.
    function automatic logic [5:0] expect_out();
        logic [NP-1:0] hit;
        logic          any, dfr;
        hit = '0;
        for (int p = 0; p < NP; p++) begin
            logic [63:0] b, c;
            logic        addr_eq, dir_ok;
            b = m_word[2*p];
            c = m_word[2*p+1];
            addr_eq = (acc_addr[63:56] == b[63:56]);
            for (int k = 0; k < 56; k++) begin
                if (c[k] && (acc_addr[k] != b[k])) addr_eq = 1'b0;
            end
            dir_ok = acc_write ? c[62] : c[63];
            hit[p] = addr_eq && dir_ok && c[56 + int'(acc_pl)];
        end
        if (!(acc_valid && dbg_enable && acc_qp && !m_skip)) hit = '0;
        any = |hit;
        dfr = defer_spec && acc_spec && !acc_write;
        return {any && !dfr, any && dfr, hit[3:0]};
    endfunction

    task automatic check(input string req, input logic [5:0] act, input logic [5:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual fault/defer/status=%b expected=%b", req, act, exp);
        end
    endtask

    // Inputs are set at a falling edge; result is compared at the next falling edge.
    task automatic step(input string req);
        logic [5:0] exp;
        exp = expect_out();
        @(posedge clk);
        if (cfg_we && int'(cfg_idx) < NW) m_word[cfg_idx] = cfg_wdata;
        if (skip_arm) m_skip = 1'b1;
        else if (acc_done) m_skip = 1'b0;
        @(negedge clk);
        check(req, {bp_fault, bp_defer, bp_status}, exp);
    endtask

    task automatic idle();
        cfg_we = 0; cfg_idx = '0; cfg_wdata = '0;
        acc_valid = 0; acc_addr = '0; acc_write = 0; acc_pl = 0;
        acc_qp = 1; acc_spec = 0; dbg_enable = 1; defer_spec = 0;
        skip_arm = 0; acc_done = 0;
    endtask

    task automatic wr(input int idx, input logic [63:0] d);
        idle();
        cfg_we = 1; cfg_idx = IW'(idx); cfg_wdata = d;
        step("R2");
    endtask

    task automatic rd_acc(input logic [63:0] a, input logic w, input logic [1:0] pl,
                          input string req);
        idle();
        acc_valid = 1; acc_addr = a; acc_write = w; acc_pl = pl;
        step(req);
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int seed;
        logic [63:0] pool [4];
        seed = $urandom(32'd5117);
        pool[0] = 64'h0000_0000_0000_1000;
        pool[1] = 64'h0000_0000_0000_9000;
        pool[2] = 64'hFF00_0000_0000_1000;
        pool[3] = 64'h0000_0000_0004_2040;
        for (int k = 0; k < NW; k++) m_word[k] = '0;
        m_skip = 0;
        idle();
        rst = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R1: outputs cleared, and zeroed words never hit
        check("R1", {bp_fault, bp_defer, bp_status}, 6'b0);
        rd_acc(64'h0, 0, 0, "R1");
        rd_acc(64'h0, 1, 3, "R1");

        // pair 0: read only, level 0, exact address
        wr(0, pool[0]);
        wr(1, mk_ctl(1, 0, 4'b0001, {56{1'b1}}));
        rd_acc(pool[0], 0, 0, "R3 R4 R5");
        check("R3", {bp_fault, bp_defer, bp_status}, 6'b10_0001);
        rd_acc(pool[0], 1, 0, "R4");
        check("R4", {bp_fault, bp_defer, bp_status}, 6'b0);
        rd_acc(pool[0], 0, 1, "R5");
        rd_acc(pool[0] | 64'h4, 0, 0, "R3");
        // masked low byte; high byte always compared
        wr(1, {1'b1, 1'b0, 2'b11, 4'b0001, ~56'hFF});
        rd_acc(pool[0] | 64'h44, 0, 0, "R3 R4");
        check("R3", {bp_fault, bp_defer, bp_status}, 6'b10_0001);
        rd_acc(pool[0] | 64'h0100_0000_0000_0000, 0, 0, "R3");

        // several pairs at once; pair 5 outside the status range
        wr(2, pool[0]);
        wr(3, mk_ctl(1, 1, 4'b1111, {56{1'b1}}));
        wr(10, pool[0]);
        wr(11, mk_ctl(1, 1, 4'b1111, {56{1'b1}}));
        rd_acc(pool[0], 0, 0, "R9");
        check("R9", {bp_fault, bp_defer, bp_status}, 6'b10_0011);
        wr(10, pool[1]);
        rd_acc(pool[1], 1, 2, "R9");
        check("R9", {bp_fault, bp_defer, bp_status}, 6'b10_0000);

        // global enable and predicate
        idle(); acc_valid = 1; acc_addr = pool[0]; dbg_enable = 0; step("R6");
        idle(); acc_valid = 1; acc_addr = pool[0]; acc_qp = 0; step("R7");

        // one-shot skip
        idle(); skip_arm = 1; step("R8");
        rd_acc(pool[0], 0, 0, "R8");
        check("R8", {bp_fault, bp_defer, bp_status}, 6'b0);
        idle(); acc_valid = 1; acc_addr = pool[0]; acc_done = 1; step("R8");
        rd_acc(pool[0], 0, 0, "R8");
        check("R8", {bp_fault, bp_defer, bp_status}, 6'b10_0011);
        idle(); skip_arm = 1; acc_done = 1; step("R8");
        rd_acc(pool[0], 0, 0, "R8");
        check("R8", {bp_fault, bp_defer, bp_status}, 6'b0);
        idle(); acc_done = 1; step("R8");

        // deferral
        idle(); acc_valid = 1; acc_addr = pool[0]; defer_spec = 1; acc_spec = 1; step("R10");
        check("R10", {bp_fault, bp_defer, bp_status}, 6'b01_0011);
        idle(); acc_valid = 1; acc_addr = pool[0]; acc_write = 1; defer_spec = 1; acc_spec = 1;
        step("R10");
        check("R10", {bp_fault, bp_defer, bp_status}, 6'b10_0010);
        idle(); acc_valid = 1; acc_addr = pool[0]; acc_spec = 1; step("R10");

        // write and access in the same cycle
        idle(); cfg_we = 1; cfg_idx = IW'(3); cfg_wdata = '0;
        acc_valid = 1; acc_addr = pool[0]; step("R2");
        check("R2", {bp_fault, bp_defer, bp_status}, 6'b10_0011);
        rd_acc(pool[0], 0, 0, "R2");
        check("R2", {bp_fault, bp_defer, bp_status}, 6'b10_0001);

        // no access
        idle(); step("R11");

        // random mix
        for (int n = 0; n < 4000; n++) begin
            logic [31:0] r;
            r = $urandom();
            idle();
            cfg_we = (r[1:0] == 0);
            cfg_idx = IW'($urandom_range(NW - 1));
            if (cfg_idx[0] == 1'b0) cfg_wdata = pool[r[3:2]];
            else cfg_wdata = {r[4], r[5], r[7:6], 4'($urandom()),
                              r[8] ? {56{1'b1}} : ~{48'h0, 8'($urandom())}};
            acc_valid = (r[11:9] != 0);
            acc_addr = pool[r[13:12]] ^ (r[14] ? 64'($urandom_range(255)) : 64'h0);
            acc_write = r[15];
            acc_pl = r[17:16];
            acc_qp = (r[20:18] != 0);
            acc_spec = r[21];
            dbg_enable = (r[24:22] != 0);
            defer_spec = r[25];
            skip_arm = (r[28:26] == 0);
            acc_done = r[29];
            step("R2 R3 R4 R5 R6 R7 R8 R9 R10 R11");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule